// File: doc/BRIEF.md
# Multichannel Soft Mute Attenuation Ramp

This block owns the attenuation levels of six audio output channels and moves each one gradually instead of letting it jump. Every channel has an 8-bit volume attenuation code in 0.5 dB units and a mute flag. While the mute flag is set, the channel heads for the ceiling code 181 (90.5 dB). When the flag is clear, the channel heads for its own volume code, capped at 181.

The current level moves one code at a time. It takes one step per programmable number of audio frames, and the frame boundaries arrive as a one-cycle strobe. A single shared frame counter sets the pace for all six channels. A 2-bit rate field in the control byte selects a step interval of 4, 8, 16 or 32 frames. The six current codes are sent out every cycle for the downstream gain stage to use.

Top module: `soft_mute_ramp`

## Requirements
- R1: During and after reset, every channel's current attenuation output is 181.
- R2: A channel whose mute bit is 1 ramps toward code 181 and then holds at 181.
- R3: A channel whose mute bit is 0 ramps toward its own volume code and then holds there.
- R4: A step changes each channel by exactly one code toward its target. A channel never passes its target, and one already at its target does not change.
- R5: With rate code 0, 1, 2 or 3 in bits 1..0 of the control byte, a step happens on every 4th, 8th, 16th or 32nd frame strobe respectively. The step takes effect at the clock edge that samples that strobe.
- R6: A volume code above 181 is treated as 181.
- R7: When a target changes in the middle of a ramp, including a reversal of direction, the ramp continues from the current value without restarting.
- R8: A change of the rate code takes effect only after the frame count that is in progress has completed.
- R9: No output changes in a cycle without a frame strobe, or on a strobe that does not complete an interval.
- R10: Bit 2+k of the control byte is the mute bit for channel k+1 (k = 0..5). Channel k+1 occupies bits 8k+7..8k of both the volume input and the attenuation output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | One-cycle strobe per audio frame |
| vol_i | input | 48 | Six volume codes, channel k+1 in bits 8k+7..8k |
| ctrl_i | input | 8 | Bits 7..2 mute channels 6..1, bits 1..0 rate code |
| att_o | output | 48 | Six current attenuation codes, same layout as vol_i |

## Verification
Every result can change at only one moment: the clock edge that samples the frame strobe completing an interval. Between those edges the outputs hold. The driver raises the strobe for exactly one cycle and lowers it at the next falling edge. At that same falling edge it advances its own model of the frame counter and the six levels, and it queues the expected codes. The monitor compares the queued codes one time unit after that falling edge, so each comparison falls exactly one register stage after the stimulus. Idle stretches queue an unchanged expectation on every cycle to confirm that nothing moves.

// File: rtl/smr_pkg.sv
package smr_pkg;

    localparam int NUM_CH   = 6;
    localparam int ATT_W    = 8;
    localparam int RATE_W   = 2;
    localparam int CNT_W    = 6;

    typedef logic [ATT_W-1:0] att_t;
    typedef logic [CNT_W-1:0] cnt_t;

    localparam att_t ATT_CEIL = att_t'(181);

    typedef enum logic [RATE_W-1:0] {
        RATE_4  = 2'd0,
        RATE_8  = 2'd1,
        RATE_16 = 2'd2,
        RATE_32 = 2'd3
    } rate_e;

    typedef struct packed {
        logic [NUM_CH-1:0] mute;
        rate_e             rate;
    } ctrl_t;

    function automatic att_t clamp_att(att_t v);
        return (v > ATT_CEIL) ? ATT_CEIL : v;
    endfunction

    function automatic att_t step_toward(att_t cur, att_t tgt);
        if (cur < tgt)      return cur + att_t'(1);
        else if (cur > tgt) return cur - att_t'(1);
        else                return cur;
    endfunction

    function automatic cnt_t rate_interval(rate_e r);
        case (r)
            RATE_4:  return cnt_t'(4);
            RATE_8:  return cnt_t'(8);
            RATE_16: return cnt_t'(16);
            default: return cnt_t'(32);
        endcase
    endfunction

endpackage

// File: rtl/smr_frame_timer.sv
module smr_frame_timer
    import smr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_i,
    input  rate_e rate_i,
    output logic  step_o
);

    cnt_t frame_cnt;
    cnt_t interval_q;
    logic restart;
    logic past_ok;

    assign restart = frame_i && (frame_cnt == interval_q - cnt_t'(1));
    assign step_o  = restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt  <= '0;
            interval_q <= rate_interval(RATE_4);
            past_ok    <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (restart) begin
                frame_cnt  <= '0;
                interval_q <= rate_interval(rate_i);
            end else if (frame_i) begin
                frame_cnt <= frame_cnt + cnt_t'(1);
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        frame_cnt < interval_q); // R5

    AST_STEP_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        step_o |-> frame_i); // R9

    AST_INTERVAL_HELD: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !restart) |=> $stable(interval_q)); // R8

    AST_NO_FRAME_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !frame_i) |=> $stable(frame_cnt)); // R9

endmodule

// File: rtl/smr_chan_ramp.sv
module smr_chan_ramp
    import smr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    input  logic mute_i,
    input  att_t vol_i,
    output att_t att_o
);

    att_t target;
    att_t cur_q;
    logic past_ok;

    assign target = mute_i ? ATT_CEIL : clamp_att(vol_i);
    assign att_o  = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= ATT_CEIL;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (step_i) begin
                cur_q <= step_toward(cur_q, target);
            end
        end
    end

    AST_NEVER_ABOVE_CEIL: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (cur_q <= ATT_CEIL)); // R6

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !step_i) |=> $stable(cur_q)); // R9

    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
        (past_ok && step_i && cur_q == target) |=> $stable(cur_q)); // R4

    AST_UP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && step_i && cur_q < target) |=> (cur_q == $past(cur_q) + att_t'(1))); // R4

    AST_DOWN_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && step_i && cur_q > target) |=> (cur_q == $past(cur_q) - att_t'(1))); // R4

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
    import smr_pkg::*;
#(
    parameter int CH  = NUM_CH,
    parameter int AW  = ATT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_i,
    input  logic [CH*AW-1:0]   vol_i,
    input  logic [CH+RATE_W-1:0] ctrl_i,
    output logic [CH*AW-1:0]   att_o
);

    localparam int CTRL_W = CH + RATE_W;

    logic              step;
    logic [CH-1:0]     mute_bits;
    rate_e             rate;

    assign mute_bits = ctrl_i[CTRL_W-1:RATE_W];
    assign rate      = rate_e'(ctrl_i[RATE_W-1:0]);

    smr_frame_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .frame_i (frame_i),
        .rate_i  (rate),
        .step_o  (step)
    );

    for (genvar k = 0; k < CH; k++) begin : g_chan
        att_t ch_att;

        smr_chan_ramp u_ramp (
            .clk    (clk),
            .rst    (rst),
            .step_i (step),
            .mute_i (mute_bits[k]),
            .vol_i  (att_t'(vol_i[k*AW +: AW])),
            .att_o  (ch_att)
        );

        assign att_o[k*AW +: AW] = ch_att;

        AST_MUTED_MOVES_UP: assert property (@(posedge clk) disable iff (rst)
            (step && mute_bits[k] && ch_att < ATT_CEIL) |=> (att_o[k*AW +: AW] > $past(ch_att))); // R2
    end

endmodule

// File: tb/soft_mute_ramp_bench.sv
module soft_mute_ramp_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_i = 1'b0;
    logic [47:0] vol_i = '0;
    logic [7:0]  ctrl_i = 8'hFC;
    logic [47:0] att_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        logic [47:0] exp;
    } item_t;

    item_t q[$];
    string cur_tag = "R1";

    int m_att[NCH];
    int m_cnt;
    int m_int;

    always #(CLK_PERIOD/2) clk = ~clk;

    soft_mute_ramp u_soft_mute_ramp (
        .clk     (clk),
        .rst     (rst),
        .frame_i (frame_i),
        .vol_i   (vol_i),
        .ctrl_i  (ctrl_i),
        .att_o   (att_o)
    );

    function automatic int clampv(int v);
        return (v > 181) ? 181 : v;
    endfunction

    function automatic logic [47:0] pack_model();
        logic [47:0] r;
        for (int k = 0; k < NCH; k++) r[k*8 +: 8] = 8'(m_att[k]);
        return r;
    endfunction

    task automatic push_expect();
        item_t it;
        it.tag = cur_tag;
        it.exp = pack_model();
        q.push_back(it);
    endtask

    task automatic model_frame();
        m_cnt++;
        if (m_cnt == m_int) begin
            m_cnt = 0;
            m_int = 4 << ctrl_i[1:0];
            for (int k = 0; k < NCH; k++) begin
                int tgt;
                tgt = ctrl_i[2+k] ? 181 : clampv(int'(vol_i[k*8 +: 8]));
                if (m_att[k] < tgt) m_att[k]++;
                else if (m_att[k] > tgt) m_att[k]--;
            end
        end
    endtask

    task automatic drive_frame(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_i = 1'b1;
            @(negedge clk);
            frame_i = 1'b0;
            model_frame();
            push_expect();
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            push_expect();
        end
    endtask

    task automatic check_ch(string tag, int ch, int exp);
        @(negedge clk);
        #2;
        checks++;
        if (int'(att_o[ch*8 +: 8]) != exp) begin
            errors++;
            $display("FAIL %s channel %0d actual %0d expected %0d", tag, ch + 1,
                     att_o[ch*8 +: 8], exp);
        end
    endtask

    task automatic set_vol(int ch, int v);
        vol_i[ch*8 +: 8] = 8'(v);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (att_o !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.tag, att_o, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NCH; k++) m_att[k] = 181;
        m_cnt = 0;
        m_int = 4;
        repeat (3) @(negedge clk);
        // R1: outputs at ceiling while in reset
        check_ch("R1", 0, 181);
        rst = 1'b0;
        cur_tag = "R1";
        idle(2);
        check_ch("R1", 5, 181);

        // R2: all muted, ramping keeps them at 181
        cur_tag = "R2";
        drive_frame(12);

        // R3 / R10: clear bit 2 only, channel 1 ramps to 170
        set_vol(0, 170);
        set_vol(1, 10);
        ctrl_i = 8'hF8;
        cur_tag = "R3";
        drive_frame(50);
        check_ch("R3", 0, 170);
        check_ch("R10", 1, 181);

        // R4 / R6: unmute all, various volumes, rate code 1
        set_vol(1, 0);
        set_vol(2, 200);
        set_vol(3, 175);
        set_vol(4, 90);
        set_vol(5, 181);
        ctrl_i = 8'h01;
        cur_tag = "R4";
        drive_frame(1500);
        check_ch("R6", 2, 181);
        check_ch("R4", 1, 0);
        check_ch("R4", 4, 90);

        // R9: no strobe, nothing moves
        cur_tag = "R9";
        idle(20);

        // R7: reversal mid-ramp, rate code 0
        ctrl_i = 8'h00;
        set_vol(0, 100);
        cur_tag = "R7";
        drive_frame(40);
        ctrl_i = 8'h04;
        drive_frame(24);
        ctrl_i = 8'h00;
        set_vol(1, 30);
        drive_frame(60);

        // R8: rate change in the middle of a count
        set_vol(0, 0);
        drive_frame(2);
        ctrl_i = 8'h03;
        cur_tag = "R8";
        drive_frame(70);

        // R5: rate codes 2 and 3
        ctrl_i = 8'h02;
        set_vol(3, 120);
        cur_tag = "R5";
        drive_frame(100);
        ctrl_i = 8'h03;
        drive_frame(130);

        // R10: mute only channel 6 via bit 7
        ctrl_i = 8'h80;
        cur_tag = "R10";
        drive_frame(200);

        idle(2);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule